// File: doc/BRIEF.md
# Reload-Match PWM Timer

This block produces one pulse-width-modulated output from a reloading down-counter. Three register fields drive it: a start value that sets the period, a match value that places the falling edge, and a polarity bit. While the enable input is high, the counter steps down by one per clock from the start value to zero. It spends one cycle at zero and then reloads. The output is active while the counter is above the match value and inactive from the match value down to zero. Both edges follow counter states and the output comes from a flop, so it cannot glitch.

The start and match values are captured into shadow registers whenever the timer is disabled and at every reload. A value written while the timer is counting therefore takes effect at the next period boundary and never cuts the current period short. The match value is classified at capture time. A zero match holds the output active for the whole period, and a match at or above the start value holds it inactive. The block raises no interrupt and no status flag. The live counter value is brought out so that the timing can be observed.

Top module: `pwm_reload_timer`

## Requirements
- R1: During reset, count is 0 and pwm_out is 0.
- R2: While enable is low, count takes the value of start_val at every clock edge and pwm_out takes the value of invert at every clock edge.
- R3: While enable is high and count is non-zero, count decreases by exactly one at each clock edge.
- R4: While enable is high and count is zero, the next clock edge loads count from start_val. The period is therefore start+1 cycles.
- R5: While enable is high and the captured match M satisfies 0 < M < S (S being the captured start), pwm_out after an edge is 1 when count before that edge was greater than M, and 0 otherwise. This holds with invert at 0.
- R6: With a captured match of 0, the raw output is active (1) for every cycle of the period.
- R7: With a captured match at or above the captured start, the raw output is inactive (0) for every cycle of the period.
- R8: With invert at 1, pwm_out is the complement of the raw level, both while enabled and while disabled.
- R9: Changes to start_val and match_val while the timer runs with count non-zero have no effect on count or pwm_out until the next reload. They apply from the cycle after the counter leaves zero.
- R10: Clearing enable in mid-period returns count to start_val and pwm_out to the inactive level at the next edge. Setting enable again starts a fresh period from the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control. High: count; low: hold at the start value |
| invert | input | 1 | Output polarity. 1 complements the raw PWM level |
| start_val | input | CNT_W | Start (period) value, captured at reload or while disabled |
| match_val | input | CNT_W | Match (duty edge) value, captured with the start value |
| count | output | CNT_W | Current counter value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The output is tried with a match value inside the period, with a zero match, with a match equal to the start and with a match above it. These cases separate the toggling compare from the two constant-level cases. Start and match values are rewritten in mid-period to show that the shadow registers hold them off until the reload, and mid-period disables show the return to the start value. The polarity bit is flipped both while running and while stopped. A long random run then varies the start values (including 0 and 1), the match values, the enable and the polarity. It is compared cycle by cycle against a bench model built from the requirements, which catches errors in the period length and in the position of the duty edges.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Level class of the raw output for one period, fixed at capture time
  typedef enum logic [1:0] {
    DUTY_TOGGLE  = 2'd0,
    DUTY_ALL_ON  = 2'd1,
    DUTY_ALL_OFF = 2'd2
  } duty_mode_e;

endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] start_in,
  input  logic [CNT_W-1:0] match_in,
  output logic [CNT_W-1:0] match_q,
  output duty_mode_e       mode_q
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  duty_mode_e mode_d;

  // Classify the pair once per period so the per-cycle compare stays short
  always_comb begin
    if (match_in == ZERO)          mode_d = DUTY_ALL_ON;
    else if (match_in >= start_in) mode_d = DUTY_ALL_OFF;
    else                           mode_d = DUTY_TOGGLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= ZERO;
      mode_q  <= DUTY_ALL_ON;
    end else if (load) begin
      match_q <= match_in;
      mode_q  <= mode_d;
    end
  end

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] start_in,
  output logic [CNT_W-1:0] count,
  output logic             reload
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  // Reload when stopped or after the one cycle spent at zero
  assign reload = !enable || (count == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= ZERO;
    else if (reload) count <= start_in;
    else             count <= count - ONE;
  end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             invert,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] match_q,
  input  duty_mode_e       mode_q,
  output logic             pwm_out
);

  logic raw_active;

  // Active from the start value down to match+1, inactive from match to zero
  always_comb begin
    unique case (mode_q)
      DUTY_ALL_ON:  raw_active = 1'b1;
      DUTY_ALL_OFF: raw_active = 1'b0;
      default:      raw_active = (count > match_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwm_out <= 1'b0;
    else if (enable) pwm_out <= raw_active ^ invert;
    else             pwm_out <= invert;
  end

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             invert,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out
);

  logic             reload;
  logic [CNT_W-1:0] match_q;
  duty_mode_e       mode_q;

  pwm_down_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start_in (start_val),
    .count    (count),
    .reload   (reload)
  );

  pwm_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .start_in (start_val),
    .match_in (match_val),
    .match_q  (match_q),
    .mode_q   (mode_q)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .invert  (invert),
    .count   (count),
    .match_q (match_q),
    .mode_q  (mode_q),
    .pwm_out (pwm_out)
  );

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             invert,
  input logic [CNT_W-1:0] start_val,
  input logic [CNT_W-1:0] match_val,
  input logic [CNT_W-1:0] count,
  input logic             pwm_out
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == $past(start_val));

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pwm_out == $past(invert));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && count != ZERO) |=> count == $past(count) - 1'b1);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && count == ZERO) |=> count == $past(start_val));

  assert_stop_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable) |-> count == $past(count) - 1'b1 || $past(count) == ZERO);

endmodule

bind pwm_reload_timer pwm_timer_checker #(.CNT_W(CNT_W)) u_pwm_chk (.*);

// File: tb/test_pwm_reload_timer.sv
module test_pwm_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic invert = 1'b0;
  logic [W-1:0] start_val = '0;
  logic [W-1:0] match_val = '0;
  wire  [W-1:0] count;
  wire          pwm_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // Requirement-level model state
  logic [W-1:0] m_cnt = '0, m_s = '0, m_m = '0;
  logic m_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_timer #(.CNT_W(W)) i_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
    .start_val(start_val), .match_val(match_val),
    .count(count), .pwm_out(pwm_out)
  );

  function automatic logic ref_active(logic [W-1:0] c, logic [W-1:0] s, logic [W-1:0] m);
    if (m == '0) return 1'b1;          // R6
    if (m >= s)  return 1'b0;          // R7
    return c > m;                      // R5
  endfunction

  function automatic string out_tag();
    if (!enable) return invert ? "R8" : "R2";
    if (m_m == '0) return "R6";
    if (m_m >= m_s) return "R7";
    if (invert) return "R8";
    return "R5";
  endfunction

  task automatic check_cnt(string req, logic [W-1:0] exp);
    n_tests++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s count actual=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic check_out(string req, logic exp);
    n_tests++;
    if (pwm_out !== exp) begin
      n_fail++;
      $display("FAIL %s pwm_out actual=%0b expected=%0b", req, pwm_out, exp);
    end
  endtask

  // One clock: inputs already driven; model advances; compare after the edge
  task automatic step(string ph);
    logic [W-1:0] n_cnt, n_s, n_m;
    logic n_out;
    string ct, ot;
    ot = (ph != "") ? ph : out_tag();
    if (!enable) begin
      n_cnt = start_val; n_s = start_val; n_m = match_val; n_out = invert;
      ct = (ph != "") ? ph : "R2";
    end else begin
      n_out = ref_active(m_cnt, m_s, m_m) ^ invert;
      if (m_cnt == '0) begin
        n_cnt = start_val; n_s = start_val; n_m = match_val;
        ct = "R4";
      end else begin
        n_cnt = m_cnt - 1'b1; n_s = m_s; n_m = m_m;
        ct = (ph != "") ? ph : "R3";
      end
    end
    @(negedge clk);
    m_cnt = n_cnt; m_s = n_s; m_m = n_m; m_out = n_out;
    check_cnt(ct, m_cnt);
    check_out(ot, m_out);
  endtask

  task automatic run(int n, string ph);
    for (int i = 0; i < n; i++) step(ph);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    start_val = 24'd10; match_val = 24'd4;
    repeat (3) @(negedge clk);
    check_cnt("R1", '0);
    check_out("R1", 1'b0);
    rst_n = 1'b1;

    // R2: disabled tracking, both polarities
    run(3, "");
    invert = 1'b1; run(2, "R8");
    start_val = 24'd7; run(2, "R2");
    invert = 1'b0; start_val = 24'd10; run(2, "");

    // R3/R4/R5: normal toggling, three periods
    enable = 1'b1; run(33, "");

    // R9: rewrite values mid-period, hold off until reload
    run(4, "");
    start_val = 24'd6; match_val = 24'd2; run(20, "");
    start_val = 24'd12; match_val = 24'd5; run(3, "R9");
    run(30, "");

    // R6: zero match; R7: match equal to and above start
    match_val = 24'd0; run(30, "");
    match_val = 24'd12; run(30, "");
    match_val = 24'd40; run(30, "");

    // R8: invert while running
    match_val = 24'd3; invert = 1'b1; run(30, "");
    invert = 1'b0;

    // R10: disable mid-period then restart
    run(5, "");
    enable = 1'b0; run(1, "R10");
    run(2, "");
    enable = 1'b1; run(15, "R10");

    // Edge starts: 0 and 1
    start_val = 24'd0; match_val = 24'd0; run(14, "");
    start_val = 24'd1; match_val = 24'd1; run(14, "");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) enable = ~enable;
      if ($urandom_range(0, 59) == 0) invert = ~invert;
      if ($urandom_range(0, 9) == 0) begin
        start_val = W'($urandom_range(0, 40));
        match_val = W'($urandom_range(0, 45));
      end
      step("");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule